// File: doc/BRIEF.md
# Packed Dual-Entry Palette RAM

This block is a 256-colour lookup table for a display pixel path. Software fills it through a register window of 128 words. Each 32-bit word carries two 16-bit colour entries. An entry holds a 5-bit red, a 5-bit green and a 5-bit blue channel, plus one intensity flag that lookups ignore.

The pixel path presents an 8-bit palette index on the lookup port. One clock later the block returns the matching colour as a 24-bit value. Each channel is widened to 8 bits by appending three zero bits.

A register read returns the stored word exactly as it was written, intensity flags included. If a register write and a lookup touch the same word in the same cycle, the lookup returns the newly written value.

Top module: `pal_lut_ram`

## Requirements
- R1: After reset every palette word reads as 0, and every lookup returns colour 0.
- R2: A write with cfg_wr at byte offset 0x200 + 4·n (n in 0..127) stores cfg_wdata in word n. cfg_addr[1:0] are ignored. A read with cfg_rd presents all 32 stored bits on cfg_rdata one clock after the request.
- R3: Offsets below 0x200 or at or above 0x400 lie outside the window. Writes there change no word, and reads there return 0.
- R4: Palette entry 2n is the low half (bits 15:0) of word n. Entry 2n+1 is the high half (bits 31:16).
- R5: Within a half, bits 4:0 are red, bits 9:5 are green and bits 14:10 are blue. pix_rgb carries red in 23:16, green in 15:8 and blue in 7:0.
- R6: Bit 15 of each half is the intensity flag. It has no effect on pix_rgb.
- R7: Each 5-bit channel becomes 8 bits by a left shift of three, so bits 2:0 of every output channel are zero.
- R8: A lookup with pix_req presents its colour on pix_rgb, with pix_valid high, one clock after the index is presented. pix_valid is low in the cycle after a cycle without pix_req.
- R9: If a lookup and a register write target the same word in the same cycle, the lookup returns the colour from the new data. A register read of the word being written in the same cycle returns the new data.
- R10: While pix_req is low, pix_rgb keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, one clock after cfg_rd |
| pix_req | input | 1 | Lookup request |
| pix_idx | input | 8 | Palette index |
| pix_valid | output | 1 | Lookup result valid |
| pix_rgb | output | 24 | Colour {R,G,B}, one clock after pix_req |

## Verification
Both result ports are registered. A register write is visible from the next clock edge on. cfg_rdata and pix_rgb are due one edge after their request.

Every task drives its stimulus on a falling edge. It samples the result on the next falling edge, which comes after exactly one rising edge, so no check samples a cycle early or late.

The same-cycle bypass is exercised by raising a write and a lookup on one falling edge. The hold behaviour is exercised by sampling one edge after pix_req falls while the index changes.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = WORD_W / 2;
    localparam int CH_IN_W = 5;
    localparam int CH_OUT_W = 8;
    localparam int N_CH    = 3;
    localparam int RGB_W   = N_CH * CH_OUT_W;
endpackage

// File: rtl/pal_win_dec.sv
module pal_win_dec #(
    parameter int ADDR_W = 12,
    parameter int BASE   = 'h200,
    parameter int WORDS  = 128,
    localparam int WA    = $clog2(WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [WA-1:0]     word
);
    localparam int LIMIT = BASE + 4 * WORDS;
    logic [ADDR_W-1:0] off;
    logic unused_off_bits;

    always_comb begin
        off  = addr - ADDR_W'(BASE);
        hit  = (int'(addr) >= BASE) && (int'(addr) < LIMIT);
        word = off[WA+1:2];
    end

    assign unused_off_bits = ^{off[ADDR_W-1:WA+2], off[1:0]};
endmodule

// File: rtl/pal_store.sv
module pal_store #(
    parameter int DEPTH = 128,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] ra_addr,
    output logic [W-1:0]  ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [W-1:0]  rb_data
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Write-first bypass on both read ports
    always_comb begin
        ra_data = (wr_en && wr_addr == ra_addr) ? wr_data : mem[ra_addr];
        rb_data = (wr_en && wr_addr == rb_addr) ? wr_data : mem[rb_addr];
    end

    // R2: a write lands in the addressed word
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/pal_expand.sv
module pal_expand
    import pal_pkg::*;
(
    input  logic [HALF_W-1:0] half,
    output logic [RGB_W-1:0]  rgb
);
    logic unused_intensity;
    assign unused_intensity = half[HALF_W-1];

    // channel 0 = red (lowest field) ends up in the top output byte
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        assign rgb[(N_CH-ch)*CH_OUT_W-1 -: CH_OUT_W] =
            {half[ch*CH_IN_W +: CH_IN_W], {(CH_OUT_W-CH_IN_W){1'b0}}};
    end
endmodule

// File: rtl/pal_lut_ram.sv
module pal_lut_ram
    import pal_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BASE   = 'h200,
    parameter int WORDS  = 128,
    localparam int WA    = $clog2(WORDS),
    localparam int IDX_W = WA + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    input  logic              pix_req,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic              pix_valid,
    output logic [RGB_W-1:0]  pix_rgb
);
    logic              win_hit;
    logic [WA-1:0]     win_word;
    logic [WORD_W-1:0] reg_word;
    logic [WORD_W-1:0] pix_word;
    logic [HALF_W-1:0] pix_half;
    logic [RGB_W-1:0]  pix_rgb_d;

    pal_win_dec #(.ADDR_W(ADDR_W), .BASE(BASE), .WORDS(WORDS)) u_dec (
        .addr(cfg_addr), .hit(win_hit), .word(win_word)
    );

    pal_store #(.DEPTH(WORDS), .W(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr && win_hit), .wr_addr(win_word), .wr_data(cfg_wdata),
        .ra_addr(win_word), .ra_data(reg_word),
        .rb_addr(pix_idx[IDX_W-1:1]), .rb_data(pix_word)
    );

    assign pix_half = pix_idx[0] ? pix_word[WORD_W-1:HALF_W] : pix_word[HALF_W-1:0];

    pal_expand u_exp (.half(pix_half), .rgb(pix_rgb_d));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_rdata <= '0;
            pix_valid <= 1'b0;
            pix_rgb   <= '0;
        end else begin
            pix_valid <= pix_req;
            if (cfg_rd)  cfg_rdata <= win_hit ? reg_word : '0;
            if (pix_req) pix_rgb   <= pix_rgb_d;
        end
    end

    // R8: a request yields a valid result one clock later
    a_r8_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |=> pix_valid);

    // R10: output held without a request
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_req |=> $stable(pix_rgb));

    // R7: low three bits of every channel are zero
    a_r7_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pix_rgb[18:16] == 3'd0 && pix_rgb[10:8] == 3'd0 && pix_rgb[2:0] == 3'd0));

    // R3: reads outside the window return zero
    a_r3_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && (int'(cfg_addr) < BASE || int'(cfg_addr) >= BASE + 4 * WORDS))
        |=> cfg_rdata == '0);

    // R9: same-cycle write reaches the lookup (red channel)
    a_r9_bypass_red: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_req && cfg_wr && win_hit && win_word == pix_idx[IDX_W-1:1])
        |=> pix_rgb[23:19] == $past(pix_idx[0] ? cfg_wdata[20:16] : cfg_wdata[4:0]));
endmodule

// File: tb/pal_lut_ram_test.sv
module pal_lut_ram_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [11:0] cfg_addr = '0;
    logic        cfg_wr = 0, cfg_rd = 0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        pix_req = 0;
    logic [7:0]  pix_idx = '0;
    logic        pix_valid;
    logic [23:0] pix_rgb;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    pal_lut_ram uut (.*);

    function automatic [23:0] exp_rgb(input [15:0] h);
        return {h[4:0], 3'b0, h[9:5], 3'b0, h[14:10], 3'b0};
    endfunction

    task automatic check(input string req, input [31:0] act, input [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input [11:0] a, input [31:0] d);
        @(negedge clk); cfg_addr = a; cfg_wr = 1; cfg_wdata = d;
        @(negedge clk); cfg_wr = 0;
    endtask

    task automatic rd(input [11:0] a, output [31:0] d);
        @(negedge clk); cfg_addr = a; cfg_rd = 1;
        @(negedge clk); d = cfg_rdata; cfg_rd = 0;
    endtask

    task automatic look(input [7:0] i, output [23:0] c, output v);
        @(negedge clk); pix_idx = i; pix_req = 1;
        @(negedge clk); c = pix_rgb; v = pix_valid; pix_req = 0;
    endtask

    task automatic t_reset;
        logic [31:0] d; logic [23:0] c; logic v;
        rd(12'h200, d); check("R1 word0", d, 0);
        rd(12'h3FC, d); check("R1 word127", d, 0);
        look(8'd255, c, v); check("R1 entry255", c, 0);
    endtask

    task automatic t_rw;
        logic [31:0] d;
        wr(12'h200, 32'h1234_5678);
        wr(12'h214, 32'hDEAD_BEEF);
        wr(12'h3FC, 32'hA5A5_5A5A);
        rd(12'h200, d); check("R2 word0", d, 32'h1234_5678);
        rd(12'h216, d); check("R2 word5 low bits ignored", d, 32'hDEAD_BEEF);
        rd(12'h3FC, d); check("R2 word127", d, 32'hA5A5_5A5A);
    endtask

    task automatic t_outside;
        logic [31:0] d;
        wr(12'h1FC, 32'hFFFF_FFFF);
        wr(12'h400, 32'hFFFF_FFFF);
        rd(12'h200, d); check("R3 word0 untouched", d, 32'h1234_5678);
        rd(12'h3FC, d); check("R3 word127 untouched", d, 32'hA5A5_5A5A);
        rd(12'h1FC, d); check("R3 below window", d, 0);
        rd(12'h400, d); check("R3 above window", d, 0);
    endtask

    task automatic t_halves;
        logic [23:0] c; logic v;
        wr(12'h228, 32'h7C00_001F);
        look(8'd20, c, v); check("R4 low half", c, 24'hF80000);
        look(8'd21, c, v); check("R4 high half", c, 24'h0000F8);
    endtask

    task automatic t_channels;
        logic [23:0] c; logic v;
        wr(12'h240, {16'h0, 1'b0, 5'd3, 5'd2, 5'd1});
        look(8'd32, c, v); check("R5 R7 channel map", c, 24'h081018);
        look(8'd0, c, v);  check("R5 entry0", c, exp_rgb(16'h5678));
        look(8'd11, c, v); check("R5 entry11", c, exp_rgb(16'hDEAD));
    endtask

    task automatic t_intensity;
        logic [31:0] d; logic [23:0] c; logic v;
        wr(12'h260, 32'h8000_8000);
        look(8'd48, c, v); check("R6 flag low half", c, 0);
        look(8'd49, c, v); check("R6 flag high half", c, 0);
        rd(12'h260, d); check("R2 R6 raw readback", d, 32'h8000_8000);
    endtask

    task automatic t_latency;
        logic [23:0] c; logic v;
        look(8'd20, c, v);
        check("R8 valid", v, 1);
        check("R8 data", c, 24'hF80000);
        @(negedge clk); pix_idx = 8'd21;
        check("R8 valid drops", pix_valid, 0);
        check("R10 hold", pix_rgb, 24'hF80000);
    endtask

    task automatic t_wfirst;
        logic [31:0] d;
        @(negedge clk);
        cfg_addr = 12'h278; cfg_wr = 1; cfg_wdata = 32'h0000_7FFF;
        pix_idx = 8'd60; pix_req = 1;
        @(negedge clk); cfg_wr = 0; pix_req = 0;
        check("R9 lookup bypass", pix_rgb, 24'hF8F8F8);
        @(negedge clk);
        cfg_addr = 12'h278; cfg_wr = 1; cfg_rd = 1; cfg_wdata = 32'h0001_0002;
        @(negedge clk); cfg_wr = 0; cfg_rd = 0;
        check("R9 read bypass", cfg_rdata, 32'h0001_0002);
        rd(12'h278, d); check("R9 stored", d, 32'h0001_0002);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_rw();
        t_outside();
        t_halves();
        t_channels();
        t_intensity();
        t_latency();
        t_wfirst();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule